// File: doc/BRIEF.md
# Word-Programmed Flash Array Controller

This block models a small on-chip flash array behind a simple request port. Software-visible writes always carry a full 32-bit word. Programming can only pull bits from 1 to 0, so the word that ends up stored is the previous contents ANDed with the supplied data. To change only some bits, the writer sets every bit that should stay the same to 1. The array is split into pages. A page erase returns every bit of that page to 1. The controller walks the page one word per clock, and `busy` is high for the whole walk.

A global write-enable input gates both programming and erasing. The controller keeps a small counter for each word. A word may be programmed at most `MAX_WRITES` times between erases, and a write that only touches some bits still counts as one write. A program request whose byte address is not word aligned is refused and reported through `fault`. A program request that would exceed the per-word limit is also refused and reported through `fault`. Reads are always accepted, including during an erase, and do not use up the write budget.

Top module: `flash_word_ctrl`

## Requirements
- R1: After reset every word reads 32'hFFFFFFFF, and `busy`, `fault` and `rd_valid` are low.
- R2: A read request returns the word at `rd_addr` (byte address; bits [1:0] ignored) on `rd_data` with `rd_valid` high in the following cycle. Reads never count toward the write limit and are served while `busy` is high.
- R3: A program request accepted with `wr_en` high stores the old word AND `wr_data`, so no bit ever returns from 0 to 1 through a write.
- R4: A program request made while `wr_en` is low has no effect on the array and does not raise `fault`.
- R5: An enabled program request with `req_addr[1:0]` not equal to 0 drives `fault` high for one cycle in the next cycle. It leaves the array unchanged and is not counted.
- R6: Each word accepts at most `MAX_WRITES` programs between erases, whatever the data, including all-ones data. A further enabled aligned program drives `fault` high for one cycle in the next cycle and is discarded.
- R7: An erase request with `wr_en` high raises `busy` in the next cycle and holds it for exactly `WORDS_PER_PAGE` cycles. Afterwards every word of the addressed page (page = word index / `WORDS_PER_PAGE`) reads all ones, and other pages are unchanged.
- R8: Erasing a page restores the full write budget of every word in that page.
- R9: While `busy` is high, program and erase requests are ignored, without any array change or `fault`.
- R10: When an erase and a program request arrive in the same cycle, the erase is taken and the program request is dropped without raising `fault`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Global enable for program and erase |
| wr_req | input | 1 | Program request strobe |
| erase_req | input | 1 | Page erase request strobe |
| req_addr | input | AW | Byte address for program or erase |
| wr_data | input | 32 | Program data (1 = keep bit) |
| rd_req | input | 1 | Read request strobe |
| rd_addr | input | AW | Byte address for read |
| rd_data | output | 32 | Read data, valid the cycle after a read request |
| rd_valid | output | 1 | Read data valid |
| busy | output | 1 | Page erase in progress |
| fault | output | 1 | One-cycle pulse for a refused program request |

## Verification
The bench keeps an arithmetic model of every word and its budget. It sweeps the whole array with patterns that clear one distinct bit per word, then layers a second pattern on top, so a design that overwrote instead of ANDing would show stray ones. It probes the write limit with all-ones data, which a design that counted only bit-changing writes would wrongly accept. It also checks that misaligned attempts leave the budget intact, which catches a design that counts refused writes. Erases are timed cycle by cycle against the page size, and the bench issues programs and erases to other pages in the middle of a walk, which would corrupt those pages if `busy` did not block them. A misaligned program paired with an erase exposes a design that does not give the erase priority.

// File: rtl/flash_pkg.sv
package flash_pkg;
    localparam int WORD_W = 32;

    typedef enum logic {
        SEQ_IDLE,
        SEQ_WALK
    } seq_state_e;

    typedef struct packed {
        logic start_erase;
        logic try_prog;
        logic misaligned;
        logic over_limit;
    } req_decode_t;

    function automatic logic [WORD_W-1:0] program_word(
        input logic [WORD_W-1:0] old_w,
        input logic [WORD_W-1:0] new_w
    );
        return old_w & new_w;
    endfunction

    function automatic logic is_aligned(input logic [1:0] lsb);
        return lsb == 2'b00;
    endfunction
endpackage

// File: rtl/flash_erase_seq.sv
module flash_erase_seq #(
    parameter int PAGES          = 4,
    parameter int WORDS_PER_PAGE = 8,
    localparam int PW = (PAGES > 1) ? $clog2(PAGES) : 1,
    localparam int WW = (WORDS_PER_PAGE > 1) ? $clog2(WORDS_PER_PAGE) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [PW-1:0] start_page,
    output logic          busy,
    output logic [PW-1:0] clr_page,
    output logic [WW-1:0] clr_word
);
    import flash_pkg::*;

    seq_state_e    state_q;
    logic [PW-1:0] page_q;
    logic [WW-1:0] word_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            page_q  <= '0;
            word_q  <= '0;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    if (start) begin
                        state_q <= SEQ_WALK;
                        page_q  <= start_page;
                        word_q  <= '0;
                    end
                end
                default: begin
                    if (word_q == WW'(WORDS_PER_PAGE - 1)) begin
                        state_q <= SEQ_IDLE;
                        word_q  <= '0;
                    end else begin
                        word_q <= word_q + 1'b1;
                    end
                end
            endcase
        end
    end

    assign busy     = (state_q == SEQ_WALK);
    assign clr_page = page_q;
    assign clr_word = word_q;
endmodule

// File: rtl/flash_wcount.sv
module flash_wcount #(
    parameter int NWORDS     = 32,
    parameter int MAX_WRITES = 2,
    localparam int IW = (NWORDS > 1) ? $clog2(NWORDS) : 1,
    localparam int CW = $clog2(MAX_WRITES + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          inc_en,
    input  logic [IW-1:0] inc_idx,
    input  logic          clr_en,
    input  logic [IW-1:0] clr_idx,
    input  logic [IW-1:0] look_idx,
    output logic          at_limit
);
    logic [CW-1:0] cnt_q [NWORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NWORDS; i++) cnt_q[i] <= '0;
        end else begin
            if (inc_en) cnt_q[inc_idx] <= cnt_q[inc_idx] + 1'b1;
            if (clr_en) cnt_q[clr_idx] <= '0;
        end
    end

    assign at_limit = (cnt_q[look_idx] >= CW'(MAX_WRITES));
endmodule

// File: rtl/flash_array.sv
module flash_array #(
    parameter int NWORDS = 32,
    localparam int IW = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          prog_en,
    input  logic [IW-1:0]                 prog_idx,
    input  logic [flash_pkg::WORD_W-1:0]  prog_data,
    input  logic                          ers_en,
    input  logic [IW-1:0]                 ers_idx,
    input  logic                          rd_en,
    input  logic [IW-1:0]                 rd_idx,
    output logic [flash_pkg::WORD_W-1:0]  rd_data,
    output logic                          rd_valid
);
    import flash_pkg::*;

    logic [WORD_W-1:0] mem_q [NWORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NWORDS; i++) mem_q[i] <= '1;
        end else begin
            if (prog_en) mem_q[prog_idx] <= program_word(mem_q[prog_idx], prog_data);
            if (ers_en)  mem_q[ers_idx]  <= '1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data  <= '1;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) rd_data <= mem_q[rd_idx];
        end
    end
endmodule

// File: rtl/flash_word_ctrl.sv
module flash_word_ctrl #(
    parameter int PAGES          = 4,
    parameter int WORDS_PER_PAGE = 8,
    parameter int MAX_WRITES     = 2,
    localparam int NWORDS = PAGES * WORDS_PER_PAGE,
    localparam int IW = (NWORDS > 1) ? $clog2(NWORDS) : 1,
    localparam int AW = IW + 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          wr_req,
    input  logic          erase_req,
    input  logic [AW-1:0] req_addr,
    input  logic [31:0]   wr_data,
    input  logic          rd_req,
    input  logic [AW-1:0] rd_addr,
    output logic [31:0]   rd_data,
    output logic          rd_valid,
    output logic          busy,
    output logic          fault
);
    import flash_pkg::*;

    localparam int PW = (PAGES > 1) ? $clog2(PAGES) : 1;
    localparam int WW = (WORDS_PER_PAGE > 1) ? $clog2(WORDS_PER_PAGE) : 1;

    logic [IW-1:0] req_idx;
    logic [IW-1:0] rd_idx;
    logic [PW-1:0] req_page;
    logic [PW-1:0] clr_page;
    logic [WW-1:0] clr_word;
    logic [IW-1:0] clr_idx;
    logic          at_limit;
    logic          do_prog;
    logic          bad_prog;
    req_decode_t   dec;

    assign req_idx  = req_addr[AW-1:2];
    assign rd_idx   = rd_addr[AW-1:2];
    assign req_page = PW'(req_idx / IW'(WORDS_PER_PAGE));
    assign clr_idx  = IW'(clr_page) * IW'(WORDS_PER_PAGE) + IW'(clr_word);

    always_comb begin
        dec.start_erase = wr_en && !busy && erase_req;
        dec.try_prog    = wr_en && !busy && wr_req && !erase_req;
        dec.misaligned  = !is_aligned(req_addr[1:0]);
        dec.over_limit  = at_limit;
    end

    assign do_prog  = dec.try_prog && !dec.misaligned && !dec.over_limit;
    assign bad_prog = dec.try_prog && (dec.misaligned || dec.over_limit);

    always_ff @(posedge clk) begin
        if (rst) fault <= 1'b0;
        else     fault <= bad_prog;
    end

    flash_erase_seq #(
        .PAGES(PAGES),
        .WORDS_PER_PAGE(WORDS_PER_PAGE)
    ) u_seq (
        .clk(clk),
        .rst(rst),
        .start(dec.start_erase),
        .start_page(req_page),
        .busy(busy),
        .clr_page(clr_page),
        .clr_word(clr_word)
    );

    flash_wcount #(
        .NWORDS(NWORDS),
        .MAX_WRITES(MAX_WRITES)
    ) u_cnt (
        .clk(clk),
        .rst(rst),
        .inc_en(do_prog),
        .inc_idx(req_idx),
        .clr_en(busy),
        .clr_idx(clr_idx),
        .look_idx(req_idx),
        .at_limit(at_limit)
    );

    flash_array #(
        .NWORDS(NWORDS)
    ) u_arr (
        .clk(clk),
        .rst(rst),
        .prog_en(do_prog),
        .prog_idx(req_idx),
        .prog_data(wr_data),
        .ers_en(busy),
        .ers_idx(clr_idx),
        .rd_en(rd_req),
        .rd_idx(rd_idx),
        .rd_data(rd_data),
        .rd_valid(rd_valid)
    );
endmodule

// File: rtl/flash_ctrl_chk.sv
module flash_ctrl_chk #(
    parameter int PAGES          = 4,
    parameter int WORDS_PER_PAGE = 8,
    parameter int MAX_WRITES     = 2,
    localparam int NWORDS = PAGES * WORDS_PER_PAGE,
    localparam int IW = (NWORDS > 1) ? $clog2(NWORDS) : 1,
    localparam int AW = IW + 2
) (
    input logic          clk,
    input logic          rst,
    input logic          wr_en,
    input logic          wr_req,
    input logic          erase_req,
    input logic [AW-1:0] req_addr,
    input logic          rd_req,
    input logic          rd_valid,
    input logic          busy,
    input logic          fault
);
    logic [31:0] run_q;

    always_ff @(posedge clk) begin
        if (rst)       run_q <= '0;
        else if (busy) run_q <= run_q + 1;
        else           run_q <= '0;
    end

    p_read_latency_r2: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> rd_valid);

    p_read_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !rd_req |=> !rd_valid);

    p_disabled_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_req && !wr_en) |=> !fault);

    p_misalign_fault_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_req && wr_en && !busy && !erase_req && req_addr[1:0] != 2'b00) |=> fault);

    p_busy_origin_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(erase_req && wr_en));

    p_busy_bound_r7: assert property (@(posedge clk) disable iff (rst)
        busy |-> (run_q < WORDS_PER_PAGE));

    p_busy_length_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (run_q == WORDS_PER_PAGE));

    p_busy_blocks_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && wr_req) |=> !fault);

    p_erase_wins_r10: assert property (@(posedge clk) disable iff (rst)
        (erase_req && wr_req && wr_en && !busy) |=> (!fault && busy));
endmodule

bind flash_word_ctrl flash_ctrl_chk #(
    .PAGES(PAGES),
    .WORDS_PER_PAGE(WORDS_PER_PAGE),
    .MAX_WRITES(MAX_WRITES)
) u_chk (
    .clk(clk),
    .rst(rst),
    .wr_en(wr_en),
    .wr_req(wr_req),
    .erase_req(erase_req),
    .req_addr(req_addr),
    .rd_req(rd_req),
    .rd_valid(rd_valid),
    .busy(busy),
    .fault(fault)
);

// File: tb/sim_flash_word_ctrl.sv
module sim_flash_word_ctrl;
    localparam int PAGES = 4;
    localparam int WPP   = 8;
    localparam int MAXW  = 2;
    localparam int NW    = PAGES * WPP;
    localparam int AW    = $clog2(NW) + 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic          wr_req = 1'b0;
    logic          erase_req = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [31:0]   wr_data = '0;
    logic          rd_req = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [31:0]   rd_data;
    logic          rd_valid;
    logic          busy;
    logic          fault;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    logic [31:0] m [NW];
    int          c [NW];

    always #2 clk = ~clk;

    flash_word_ctrl #(.PAGES(PAGES), .WORDS_PER_PAGE(WPP), .MAX_WRITES(MAXW)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_req(wr_req), .erase_req(erase_req),
        .req_addr(req_addr), .wr_data(wr_data), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy), .fault(fault)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_erase(input int pg);
        for (int w = pg * WPP; w < (pg + 1) * WPP; w++) begin
            m[w] = '1;
            c[w] = 0;
        end
    endtask

    task automatic rd(input string req, input int w);
        @(negedge clk);
        rd_req  = 1'b1;
        rd_addr = AW'(w * 4);
        @(negedge clk);
        rd_req = 1'b0;
        chk(req, {31'd0, rd_valid}, 32'd1);
        chk(req, rd_data, m[w]);
    endtask

    task automatic check_all(input string req);
        for (int w = 0; w < NW; w++) rd(req, w);
    endtask

    task automatic wr(input string req, input int baddr, input logic [31:0] d, input logic en);
        int  wi;
        logic ef;
        wi = baddr / 4;
        ef = en && ((baddr % 4) != 0 || c[wi] >= MAXW);
        if (en && !ef) begin
            m[wi] = m[wi] & d;
            c[wi]++;
        end
        @(negedge clk);
        wr_en    = en;
        wr_req   = 1'b1;
        req_addr = AW'(baddr);
        wr_data  = d;
        @(negedge clk);
        wr_req = 1'b0;
        wr_en  = 1'b0;
        chk(req, {31'd0, fault}, {31'd0, ef});
    endtask

    task automatic erase(input string req, input int pg);
        int n;
        @(negedge clk);
        wr_en     = 1'b1;
        erase_req = 1'b1;
        req_addr  = AW'(pg * WPP * 4);
        @(negedge clk);
        erase_req = 1'b0;
        wr_en     = 1'b0;
        n = 0;
        while (busy && n < 100) begin
            n++;
            @(negedge clk);
        end
        chk(req, 32'(n), 32'(WPP));
        model_erase(pg);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int w = 0; w < NW; w++) begin
            m[w] = '1;
            c[w] = 0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1", {29'd0, busy, fault, rd_valid}, 32'd0);
        check_all("R1");

        // R3 first layer: each word clears its own bit
        for (int w = 0; w < NW; w++) wr("R3", w * 4, ~(32'h1 << w), 1'b1);
        check_all("R3");
        // R3 second layer: mixed pattern ANDed on top
        for (int w = 0; w < NW; w++) wr("R3", w * 4, {16'hF0F0, 16'(w * 37 + 5)} | 32'h0001_0000, 1'b1);
        check_all("R3");

        // R6 budget exhausted across page 0
        for (int w = 0; w < WPP; w++) wr("R6", w * 4, 32'h0, 1'b1);
        check_all("R6");

        // R4 disabled write to a fresh page
        erase("R7", 2);
        wr("R4", (2 * WPP) * 4, 32'h0, 1'b0);
        rd("R4", 2 * WPP);

        // R5 misaligned attempts leave word and budget untouched
        for (int off = 1; off < 4; off++) wr("R5", (2 * WPP + 1) * 4 + off, 32'h0, 1'b1);
        rd("R5", 2 * WPP + 1);
        wr("R5", (2 * WPP + 1) * 4, 32'hFFFF_00FF, 1'b1);
        wr("R5", (2 * WPP + 1) * 4, 32'h0F0F_FFFF, 1'b1);
        wr("R6", (2 * WPP + 1) * 4, 32'h0, 1'b1);
        rd("R6", 2 * WPP + 1);

        // R6 all-ones writes still spend the budget
        for (int k = 0; k < MAXW + 1; k++) wr("R6", (2 * WPP + 2) * 4, (k < MAXW) ? 32'hFFFF_FFFF : 32'h0, 1'b1);
        rd("R6", 2 * WPP + 2);

        // R7 / R8 erase page 0 restores values and budget
        erase("R7", 0);
        check_all("R7");
        for (int w = 0; w < WPP; w++) begin
            wr("R8", w * 4, 32'h1234_5678 ^ 32'(w), 1'b1);
            wr("R8", w * 4, 32'hFFFF_FF00, 1'b1);
        end
        check_all("R8");

        // R9 requests during an erase walk are ignored; reads are served
        @(negedge clk);
        wr_en = 1'b1;
        erase_req = 1'b1;
        req_addr = AW'(1 * WPP * 4);
        @(negedge clk);
        erase_req = 1'b0;
        wr_req = 1'b1;
        req_addr = AW'(3 * WPP * 4);
        wr_data = 32'h0;
        @(negedge clk);
        wr_req = 1'b0;
        chk("R9", {31'd0, fault}, 32'd0);
        erase_req = 1'b1;
        req_addr = AW'(3 * WPP * 4 + 4);
        @(negedge clk);
        erase_req = 1'b0;
        wr_en = 1'b0;
        rd_req = 1'b1;
        rd_addr = AW'(3 * WPP * 4);
        @(negedge clk);
        rd_req = 1'b0;
        chk("R9", {31'd0, rd_valid}, 32'd1);
        chk("R9", rd_data, m[3 * WPP]);
        begin
            int n;
            n = 0;
            while (busy && n < 100) begin
                n++;
                @(negedge clk);
            end
        end
        model_erase(1);
        check_all("R9");

        // R10 erase beats a misaligned program in the same cycle
        @(negedge clk);
        wr_en = 1'b1;
        erase_req = 1'b1;
        wr_req = 1'b1;
        req_addr = AW'(3 * WPP * 4 + 2);
        wr_data = 32'h0;
        @(negedge clk);
        erase_req = 1'b0;
        wr_req = 1'b0;
        wr_en = 1'b0;
        chk("R10", {30'd0, busy, fault}, 32'd2);
        begin
            int n;
            n = 0;
            while (busy && n < 100) begin
                n++;
                @(negedge clk);
            end
        end
        model_erase(3);
        check_all("R10");

        // R2 reads do not consume budget
        for (int k = 0; k < 4; k++) rd("R2", 3 * WPP + 5);
        wr("R2", (3 * WPP + 5) * 4, 32'hAAAA_AAAA, 1'b1);
        wr("R2", (3 * WPP + 5) * 4, 32'h5555_FFFF, 1'b1);
        rd("R2", 3 * WPP + 5);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule